// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block sits between an instruction fetch path and an execution unit for a processor whose instructions carry no operands. Every 18-bit fetched word packs four instructions. The three leading slots are each five bits wide and can name any of 32 opcodes. The trailing slot has only three bits. The sequencer takes one word at a time and issues one opcode per clock, from the leading slot to the trailing slot. When the trailing slot is on issue, it asks for the next word.

A trailing-slot value reaches only a subset of the opcode space. Its three bits become the upper bits of a five-bit opcode, and the two low bits are zero. The execution side can assert a flush while an opcode that ends the word is on issue, such as a jump. The slots that remain in the word are then dropped and a fetch is requested at once. The fetch handshake is simple. A word is taken on a clock edge where the fetch request and the word-valid input are both high. If no word is present, issue stops until one arrives.

Top module: `pack_issue_seq`

## Requirements
- R1: After a clock edge with rst_n low, issue_valid is 0, issue_slot is 0 and fetch_req is 1.
- R2: A word is taken on an edge where fetch_req and word_valid are both high. Over the next cycles, issue_valid stays high and issue_slot goes 0, 1, 2, 3, one step per cycle.
- R3: In slots 0, 1 and 2, issue_op is word bits 17:13, 12:8 and 7:3 respectively.
- R4: In slot 3, issue_op is word bits 2:0 followed by two zero bits, so issue_op[1:0] is always 00 there.
- R5: fetch_req is high whenever no word is held or slot 3 is on issue. It is low while slots 0 to 2 are on issue and flush is low.
- R6: If word_valid is high in the cycle slot 3 is on issue, slot 0 of the new word issues in the next cycle, with no gap.
- R7: If fetch_req is high and word_valid is low, issue_valid is 0 in the next cycle. It stays 0 until a word is taken.
- R8: While flush is high, fetch_req is high in that same cycle, and the opcode on issue in that cycle counts as issued. In the next cycle, slot 0 of the new word issues if word_valid was high; otherwise issue_valid is 0. The rest of the old word never issues.
- R9: word_valid is ignored while fetch_req is low, and the held word keeps issuing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Fetched word is present on word_data |
| word_data | input | 18 | Packed instruction word |
| flush | input | 1 | The opcode now on issue ends the word; restart the fetch |
| fetch_req | output | 1 | Sequencer will accept a word at the next edge |
| issue_valid | output | 1 | issue_op carries an opcode this cycle |
| issue_op | output | 5 | Opcode on issue |
| issue_slot | output | 2 | Slot index of the opcode on issue |

## Verification
fetch_req depends combinationally on flush and on the held state, so it is due in the same cycle as the input that causes it. Everything else is registered. A word taken at an edge shows up as slot 0 in the cycle after that edge, and a flush or a stall takes effect on issue_valid exactly one edge later. The bench drives its inputs just after the falling edge and compares all outputs against a queue model shortly afterwards. It then advances the model by one edge, so every comparison falls in the cycle the requirement names.

// File: rtl/pis_pkg.sv
// Shared definitions for the packed instruction slot sequencer.
// Assumes one word is accepted at most once per cycle.
package pis_pkg;
    // Action taken by the sequencer at the coming clock edge.
    typedef enum logic [1:0] {
        ACT_STEP = 2'd0,  // advance to the next slot of the held word
        ACT_LOAD = 2'd1,  // take a new word and start at slot 0
        ACT_DROP = 2'd2   // nothing to issue next: release the held word
    } seq_act_e;
endpackage

// File: rtl/pis_ctrl.sv
// Control decision for the slot sequencer. It raises the fetch request
// when no word is held, when the last slot is on issue, or on a flush.
// It then chooses the action for the next edge.
// Assumes word_valid is meaningful only while fetch_req is high.
module pis_ctrl
    import pis_pkg::*;
(
    input  logic     have_word,
    input  logic     last_slot,
    input  logic     flush,
    input  logic     word_valid,
    output logic     fetch_req,
    output seq_act_e act
);
    // Fetch decision and next-edge action.
    always_comb begin
        fetch_req = !have_word || last_slot || flush;
        if (!fetch_req) begin
            act = ACT_STEP;
        end else if (word_valid) begin
            act = ACT_LOAD;
        end else begin
            act = ACT_DROP;
        end
    end
endmodule

// File: rtl/pis_slot_ctr.sv
// Slot counter. It steps once per issued opcode and returns to zero when
// a word is loaded or dropped. It also flags the last slot of a word.
// Assumes STEP is never requested on the last slot.
module pis_slot_ctr
    import pis_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_act_e         act,
    output logic [CNT_W-1:0] slot,
    output logic             last_slot
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

    // Slot index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (act == ACT_STEP) begin
            slot <= slot + 1'b1;
        end else begin
            slot <= '0;
        end
    end

    // Last-slot flag.
    always_comb last_slot = (slot == LAST);
endmodule

// File: rtl/pis_word_reg.sv
// Holds the word now being issued, together with its presence flag.
// Assumes the word changes only on a LOAD action.
module pis_word_reg
    import pis_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_act_e          act,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_q,
    output logic              have_word
);
    // Presence flag: set on load, cleared on drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_word <= 1'b0;
        end else if (act == ACT_LOAD) begin
            have_word <= 1'b1;
        end else if (act == ACT_DROP) begin
            have_word <= 1'b0;
        end
    end

    // Word storage, captured on load only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (act == ACT_LOAD) begin
            word_q <= word_in;
        end
    end
endmodule

// File: rtl/pis_slot_mux.sv
// Splits a packed word into slot opcodes and selects the one for the
// current slot. Full-width slots are taken from the top of the word
// downward. The short trailing slot fills the upper opcode bits and
// leaves the low bits zero.
// Assumes TAIL_W <= OP_W.
module pis_slot_mux #(
    parameter int OP_W   = 5,
    parameter int SLOTS  = 4,
    parameter int TAIL_W = 3,
    localparam int WORD_W = (SLOTS - 1) * OP_W + TAIL_W,
    localparam int CNT_W  = $clog2(SLOTS)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  slot,
    output logic [OP_W-1:0]   op
);
    logic [OP_W-1:0] field [SLOTS];

    genvar gi;
    generate
        for (gi = 0; gi < SLOTS - 1; gi++) begin : g_full
            // Full-width slot extraction, most significant slot first.
            assign field[gi] = word[WORD_W-1-gi*OP_W -: OP_W];
        end
        if (TAIL_W == OP_W) begin : g_tail_full
            // Trailing slot is full width.
            assign field[SLOTS-1] = word[TAIL_W-1:0];
        end else begin : g_tail_short
            // Trailing slot expansion: the field lands in the high bits.
            assign field[SLOTS-1] = {word[TAIL_W-1:0], {(OP_W-TAIL_W){1'b0}}};
        end
    endgenerate

    // Slot selection.
    always_comb op = field[slot];
endmodule

// File: rtl/pack_issue_seq.sv
// Packed instruction slot sequencer. It accepts one packed word through a
// request/valid handshake and issues its opcodes one per cycle. A flush
// drops the slots that remain and restarts the fetch.
// Assumes the fetch side may present a word in the same cycle as the request.
module pack_issue_seq
    import pis_pkg::*;
#(
    parameter int OP_W   = 5,
    parameter int SLOTS  = 4,
    parameter int TAIL_W = 3,
    localparam int WORD_W = (SLOTS - 1) * OP_W + TAIL_W,
    localparam int CNT_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              flush,
    output logic              fetch_req,
    output logic              issue_valid,
    output logic [OP_W-1:0]   issue_op,
    output logic [CNT_W-1:0]  issue_slot
);
    seq_act_e          act;
    logic              have_word;
    logic              last_slot;
    logic [CNT_W-1:0]  slot;
    logic [WORD_W-1:0] word_q;

    pis_ctrl u_ctrl (
        .have_word (have_word),
        .last_slot (last_slot),
        .flush     (flush),
        .word_valid(word_valid),
        .fetch_req (fetch_req),
        .act       (act)
    );

    pis_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .slot     (slot),
        .last_slot(last_slot)
    );

    pis_word_reg #(.WORD_W(WORD_W)) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .word_in  (word_data),
        .word_q   (word_q),
        .have_word(have_word)
    );

    pis_slot_mux #(.OP_W(OP_W), .SLOTS(SLOTS), .TAIL_W(TAIL_W)) u_mux (
        .word(word_q),
        .slot(slot),
        .op  (issue_op)
    );

    // Issue-side outputs.
    always_comb begin
        issue_valid = have_word;
        issue_slot  = slot;
    end
endmodule

// File: rtl/pis_checker.sv
// Temporal checks on the sequencer's ports, attached by bind.
module pis_checker #(
    parameter int OP_W  = 5,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_valid,
    input logic             flush,
    input logic             fetch_req,
    input logic             issue_valid,
    input logic [OP_W-1:0]  issue_op,
    input logic [CNT_W-1:0] issue_slot
);
    localparam logic [CNT_W-1:0] LAST = '1;

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !issue_valid && issue_slot == '0);

    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !fetch_req |=> issue_valid && issue_slot == CNT_W'($past(issue_slot) + 1'b1));

    a_r4_tail_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_slot == LAST |-> issue_op[1:0] == 2'b00);

    a_r5_tail_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_slot == LAST) || !issue_valid |-> fetch_req);

    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !word_valid |=> !issue_valid);

    a_r8_flush_load: assert property (@(posedge clk) disable iff (!rst_n)
        flush && word_valid |=> issue_valid && issue_slot == '0);

    a_r8_flush_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> fetch_req);
endmodule

bind pack_issue_seq pis_checker #(.OP_W(OP_W), .CNT_W(CNT_W)) u_pis_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .flush      (flush),
    .fetch_req  (fetch_req),
    .issue_valid(issue_valid),
    .issue_op   (issue_op),
    .issue_slot (issue_slot)
);

// File: tb/pack_issue_seq_tb.sv
// Bench: a queue of pending opcodes is the reference, checked every cycle.
module pack_issue_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [17:0] word_data = '0;
    logic        flush = 1'b0;
    logic        fetch_req;
    logic        issue_valid;
    logic [4:0]  issue_op;
    logic [1:0]  issue_slot;

    int checks = 0;
    int failures = 0;
    logic [4:0] pend[$];

    always #4 clk = ~clk;

    pack_issue_seq u_dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .flush(flush), .fetch_req(fetch_req), .issue_valid(issue_valid),
        .issue_op(issue_op), .issue_slot(issue_slot)
    );

    // Opcodes of a word in issue order, from the field layout in R3 and R4.
    function automatic void expand(input logic [17:0] w);
        pend.delete();
        pend.push_back(w[17:13]);
        pend.push_back(w[12:8]);
        pend.push_back(w[7:3]);
        pend.push_back({w[2:0], 2'b00});
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, then advance the model.
    task automatic step(input string tag, input logic v, input logic [17:0] d, input logic f);
        bit exp_fetch;
        @(negedge clk);
        word_valid = v;
        word_data  = d;
        flush      = f;
        #1;
        exp_fetch = (pend.size() <= 1) || f;
        check(tag, "issue_valid", int'(issue_valid), int'(pend.size() > 0));
        check(tag, "fetch_req", int'(fetch_req), int'(exp_fetch));
        if (pend.size() > 0) begin
            check(tag, "issue_op", int'(issue_op), int'(pend[0]));
            check(tag, "issue_slot", int'(issue_slot), 4 - pend.size());
        end
        if (exp_fetch && v) begin
            expand(d);
        end else if (exp_fetch) begin
            pend.delete();
        end else begin
            void'(pend.pop_front());
        end
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "issue_valid", int'(issue_valid), 0);
        check("R1", "issue_slot", int'(issue_slot), 0);
        check("R1", "fetch_req", int'(fetch_req), 1);
        rst_n = 1'b1;
        // R2 R3 R4: one word, then stall (R7)
        step("R2", 1'b1, 18'b10101_01100_11111_101, 1'b0);
        for (int i = 0; i < 4; i++) step("R3", 1'b0, '0, 1'b0);
        for (int i = 0; i < 3; i++) step("R7", 1'b0, '0, 1'b0);
        // R6: back-to-back words
        step("R6", 1'b1, 18'h2A5C3, 1'b0);
        for (int i = 0; i < 3; i++) step("R6", 1'b0, '0, 1'b0);
        step("R6", 1'b1, 18'h1F00F, 1'b0);
        for (int i = 0; i < 3; i++) step("R4", 1'b0, '0, 1'b0);
        step("R6", 1'b1, 18'h00007, 1'b0);
        // R9: valid while not fetching is ignored
        for (int i = 0; i < 2; i++) step("R9", 1'b1, 18'h3FFF8, 1'b0);
        step("R5", 1'b0, '0, 1'b0);
        step("R7", 1'b0, '0, 1'b0);
        // R8: flush at slot 0 with a new word, then flush without one
        step("R8", 1'b1, 18'h12345, 1'b0);
        step("R8", 1'b1, 18'h0BEEF, 1'b1);
        step("R8", 1'b0, '0, 1'b0);
        step("R8", 1'b0, '0, 1'b1);
        step("R8", 1'b0, '0, 1'b0);
        // R5: mixed traffic
        for (int i = 0; i < 400; i++)
            step("R5", 1'($urandom_range(0, 1)), 18'($urandom), 1'($urandom_range(0, 5) == 0));
        step("R5", 1'b0, '0, 1'b0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule